// File: doc/BRIEF.md
# Mailbox Receive-Pending Flag Register

This block holds one pending bit for each of sixteen CAN receive mailboxes. A receive engine reports every completed store with a single-cycle strobe. The strobe carries a 4-bit mailbox index and a frame-type qualifier that marks the frame as data or remote. The matching bit sets only when two things are both true: the frame is a data frame, and the configuration input for that mailbox enables data-frame reception.

Software reads all sixteen bits at once over a simple 16-bit register port. It clears bits by writing ones to them. A per-mailbox mask decides which pending bits feed a summary receive flag. A global mask then decides whether the summary flag drives the interrupt line. The protocol engine, the mailbox storage and the configuration registers sit outside this block and appear only as inputs.

Top module: `rx_pending_flags`

## Requirements
- R1: `bus_rdata` bit n shows the pending flag of mailbox n for n = 0..15. Reading has no side effect, so the value stays stable while no store and no write occur.
- R2: While `rst` is high at a clock edge, all flags clear to 0. After that edge, `sum_flag` and `irq` are 0 until a flag sets.
- R3: On a clock edge with `bus_wr` = 1, each flag whose `bus_wdata` bit is 1 clears. Bits written as 0 keep their value. A write never sets a flag.
- R4: A store strobe (`st_valid` = 1, `st_remote` = 0, `cfg_rx_data[st_index]` = 1) sets flag `st_index` at that clock edge. The set is visible on `bus_rdata` one cycle after the strobe, and no other flag changes.
- R5: A store strobe for a mailbox whose `cfg_rx_data` bit is 0 leaves every flag unchanged.
- R6: A store strobe with `st_remote` = 1 (remote frame) leaves every flag unchanged, even when the mailbox is enabled for reception.
- R7: When a qualifying store and a write-1-clear hit the same bit at the same edge, the bit ends up set.
- R8: `sum_flag` is the OR of all flags whose `mb_mask` bit is 0. It falls by itself once every such flag is cleared or masked.
- R9: `irq` is 1 exactly when `sum_flag` is 1 and `glb_mask` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Single-cycle store-complete strobe |
| st_index | input | 4 | Mailbox index of the store |
| st_remote | input | 1 | 1 = remote frame, 0 = data frame |
| cfg_rx_data | input | 16 | Per-mailbox enable for data-frame reception |
| bus_wr | input | 1 | Write strobe (write-1-to-clear) |
| bus_wdata | input | 16 | Write data; ones clear the matching flags |
| bus_rdata | output | 16 | Current pending flags |
| mb_mask | input | 16 | Per-mailbox summary mask, 1 = masked |
| glb_mask | input | 1 | Global interrupt mask, 1 = masked |
| sum_flag | output | 1 | Summary data-frame-received flag |
| irq | output | 1 | Receive interrupt output |

## Verification
The flags are the only state in the block. A store or a write applied before a clock edge therefore shows on `bus_rdata` right after that edge, one cycle later. `sum_flag` and `irq` follow the flags and the masks within the same cycle, with no added delay.

The bench drives every input on the falling edge. It lets exactly one rising edge pass, and samples on the next falling edge. At that point the flags reflect the stimulus while the masks are still held. Mask-only changes are checked on the falling edge itself, with no clock edge in between.

// File: rtl/rxpend_pkg.sv
package rxpend_pkg;

    localparam int MB_COUNT = 16;
    localparam int IDX_W    = $clog2(MB_COUNT);

    typedef logic [MB_COUNT-1:0] mb_vec_t;
    typedef logic [IDX_W-1:0]    mb_idx_t;

    typedef enum logic {
        FRM_DATA   = 1'b0,
        FRM_REMOTE = 1'b1
    } frame_kind_e;

    typedef struct packed {
        logic        valid;
        mb_idx_t     idx;
        frame_kind_e kind;
    } store_ev_t;

    function automatic mb_vec_t idx_onehot(input mb_idx_t idx);
        mb_vec_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/rxpend_qualify.sv
module rxpend_qualify
    import rxpend_pkg::*;
(
    input  store_ev_t ev,
    input  mb_vec_t   cfg_rx_data,
    output mb_vec_t   set_vec
);
    logic ev_is_data;
    assign ev_is_data = ev.valid && (ev.kind == FRM_DATA);

    for (genvar i = 0; i < MB_COUNT; i++) begin : g_bit
        assign set_vec[i] = ev_is_data && (ev.idx == mb_idx_t'(i)) && cfg_rx_data[i];
    end
endmodule

// File: rtl/rxpend_flagbank.sv
module rxpend_flagbank
    import rxpend_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  mb_vec_t set_vec,
    input  mb_vec_t clr_vec,
    output mb_vec_t flags
);
    for (genvar i = 0; i < MB_COUNT; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (set_vec[i])
                flags[i] <= 1'b1;   // set beats a simultaneous clear
            else if (clr_vec[i])
                flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/rxpend_irqgate.sv
module rxpend_irqgate
    import rxpend_pkg::*;
(
    input  mb_vec_t flags,
    input  mb_vec_t mb_mask,
    input  logic    glb_mask,
    output logic    sum_flag,
    output logic    irq
);
    mb_vec_t live;
    assign live     = flags & ~mb_mask;
    assign sum_flag = |live;
    assign irq      = sum_flag & ~glb_mask;
endmodule

// File: rtl/rx_pending_flags.sv
module rx_pending_flags
    import rxpend_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                st_valid,
    input  logic [IDX_W-1:0]    st_index,
    input  logic                st_remote,
    input  logic [MB_COUNT-1:0] cfg_rx_data,
    input  logic                bus_wr,
    input  logic [MB_COUNT-1:0] bus_wdata,
    output logic [MB_COUNT-1:0] bus_rdata,
    input  logic [MB_COUNT-1:0] mb_mask,
    input  logic                glb_mask,
    output logic                sum_flag,
    output logic                irq
);
    store_ev_t ev;
    mb_vec_t   set_vec;
    mb_vec_t   clr_vec;
    mb_vec_t   flags;

    assign ev.valid = st_valid;
    assign ev.idx   = st_index;
    assign ev.kind  = st_remote ? FRM_REMOTE : FRM_DATA;

    assign clr_vec  = bus_wr ? bus_wdata : '0;

    rxpend_qualify u_qual (
        .ev          (ev),
        .cfg_rx_data (cfg_rx_data),
        .set_vec     (set_vec)
    );

    rxpend_flagbank u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (flags)
    );

    rxpend_irqgate u_gate (
        .flags    (flags),
        .mb_mask  (mb_mask),
        .glb_mask (glb_mask),
        .sum_flag (sum_flag),
        .irq      (irq)
    );

    assign bus_rdata = flags;
endmodule

// File: rtl/rx_pending_chk.sv
module rx_pending_chk
    import rxpend_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                st_valid,
    input logic [IDX_W-1:0]    st_index,
    input logic                st_remote,
    input logic [MB_COUNT-1:0] cfg_rx_data,
    input logic                bus_wr,
    input logic [MB_COUNT-1:0] bus_wdata,
    input logic [MB_COUNT-1:0] bus_rdata,
    input logic [MB_COUNT-1:0] mb_mask,
    input logic                glb_mask,
    input logic                sum_flag,
    input logic                irq
);
    logic    qual;
    mb_vec_t hit;
    assign qual = st_valid && !st_remote && cfg_rx_data[st_index];
    assign hit  = qual ? idx_onehot(st_index) : '0;

    // R2: a reset edge leaves all flags clear
    a_r2_reset_clear: assert property (@(posedge clk) rst |=> (bus_rdata == '0));

    // R4, R7: a qualifying store always shows up next cycle
    a_r4_store_sets: assert property (@(posedge clk) disable iff (rst)
        qual |=> bus_rdata[$past(st_index)]);

    // R5, R6: a flag can only rise through a qualifying store
    a_r6_rise_needs_store: assert property (@(posedge clk) disable iff (rst)
        ((bus_rdata & ~$past(bus_rdata)) & ~$past(hit)) == '0);

    // R3: written ones clear, unless a store hits that bit
    a_r3_w1c: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> ((bus_rdata & $past(bus_wdata) & ~$past(hit)) == '0));

    // R8: summary follows the unmasked flags
    a_r8_summary: assert property (@(posedge clk) disable iff (rst)
        sum_flag == ((bus_rdata & ~mb_mask) != '0));

    // R9: global mask silences the line
    a_r9_glb_mask: assert property (@(posedge clk) disable iff (rst)
        glb_mask |-> !irq);

    a_r9_irq_needs_sum: assert property (@(posedge clk) disable iff (rst)
        irq |-> sum_flag);
endmodule

bind rx_pending_flags rx_pending_chk u_chk (.*);

// File: tb/tb_rx_pending_flags.sv
module tb_rx_pending_flags;
    logic        clk = 1'b0;
    logic        rst;
    logic        st_valid, st_remote, bus_wr, glb_mask;
    logic [3:0]  st_index;
    logic [15:0] cfg_rx_data, bus_wdata, mb_mask;
    logic [15:0] bus_rdata;
    logic        sum_flag, irq;

    int checks = 0;
    int fails  = 0;
    logic [15:0] model = '0;

    always #4 clk = ~clk;   // 125 MHz

    rx_pending_flags dut (.*);

    typedef struct packed {
        logic        v;
        logic [3:0]  idx;
        logic        rem;
        logic [15:0] cfg;
        logic        wr;
        logic [15:0] wd;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 4'd3,  1'b0, 16'hFFFF, 1'b0, 16'h0000},
        '{1'b1, 4'd0,  1'b0, 16'hFFFE, 1'b0, 16'h0000},
        '{1'b1, 4'd15, 1'b1, 16'hFFFF, 1'b0, 16'h0000},
        '{1'b1, 4'd15, 1'b0, 16'hFFFF, 1'b0, 16'h0000},
        '{1'b1, 4'd5,  1'b0, 16'hFFFF, 1'b0, 16'h0000},
        '{1'b0, 4'd2,  1'b0, 16'hFFFF, 1'b1, 16'h0000},
        '{1'b0, 4'd0,  1'b0, 16'hFFFF, 1'b1, 16'h0008},
        '{1'b1, 4'd7,  1'b0, 16'hFFFF, 1'b1, 16'h8000},
        '{1'b1, 4'd9,  1'b1, 16'h0000, 1'b0, 16'h0000},
        '{1'b0, 4'd0,  1'b0, 16'hFFFF, 1'b1, 16'hFFFF}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outs(input string tag);
        logic s;
        s = |(model & ~mb_mask);
        check({tag, " R1 flags"}, bus_rdata, model);
        check({tag, " R8 sum"}, {15'd0, sum_flag}, {15'd0, s});
        check({tag, " R9 irq"}, {15'd0, irq}, {15'd0, s & ~glb_mask});
    endtask

    // apply one cycle of stimulus, update model, sample at next falling edge
    task automatic step(input logic v, input logic [3:0] idx, input logic rem,
                        input logic [15:0] cfg, input logic wr, input logic [15:0] wd);
        logic [15:0] setv;
        st_valid = v; st_index = idx; st_remote = rem; cfg_rx_data = cfg;
        bus_wr = wr; bus_wdata = wd;
        setv = (v && !rem && cfg[idx]) ? (16'h1 << idx) : 16'h0;
        @(posedge clk);
        model = (model & ~(wr ? wd : 16'h0)) | setv;
        @(negedge clk);
        st_valid = 1'b0; bus_wr = 1'b0;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; st_valid = 0; st_index = 0; st_remote = 0; bus_wr = 0;
        bus_wdata = 0; cfg_rx_data = 16'hFFFF; mb_mask = 16'h00F0; glb_mask = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model = '0;
        check_outs("R2 reset");

        // table walk: R4 set, R5 cfg off, R6 remote, R3 write-one-clear, R7 collision
        for (int i = 0; i < NV; i++) begin
            step(TBL[i].v, TBL[i].idx, TBL[i].rem, TBL[i].cfg, TBL[i].wr, TBL[i].wd);
            check_outs($sformatf("R4/R3 table row %0d", i));
        end

        // R3: a write can never set a flag
        step(1'b0, 4'd0, 1'b0, 16'hFFFF, 1'b1, 16'h0000);
        check("R3 write cannot set", bus_rdata, 16'h0000);

        // R5: disabled mailbox ignores a data frame
        step(1'b1, 4'd12, 1'b0, 16'hEFFF, 1'b0, 16'h0);
        check("R5 cfg off", bus_rdata, 16'h0000);

        // R6: remote frame into an enabled mailbox
        step(1'b1, 4'd1, 1'b1, 16'hFFFF, 1'b0, 16'h0);
        check("R6 remote", bus_rdata, 16'h0000);

        // R4: set mailbox 0 and 10
        step(1'b1, 4'd0, 1'b0, 16'hFFFF, 1'b0, 16'h0);
        step(1'b1, 4'd10, 1'b0, 16'hFFFF, 1'b0, 16'h0);
        check("R4 two sets", bus_rdata, 16'h0401);

        // R1: reads have no side effect; value stable over idle cycles
        repeat (3) @(negedge clk);
        check("R1 stable read", bus_rdata, 16'h0401);

        // R7: set and clear same bit same edge -> set wins
        step(1'b1, 4'd10, 1'b0, 16'hFFFF, 1'b1, 16'h0400);
        check("R7 set wins", bus_rdata, 16'h0401);

        // R9: global mask blocks irq, mask change seen without a clock edge
        glb_mask = 1'b1; #1;
        check("R9 glb masked irq", {15'd0, irq}, 16'h0);
        check("R8 sum unaffected by glb", {15'd0, sum_flag}, 16'h1);
        glb_mask = 1'b0; #1;
        check("R9 irq unmasked", {15'd0, irq}, 16'h1);

        // R8: masking all pending mailboxes drops summary
        mb_mask = 16'h0401; #1;
        check("R8 all masked", {15'd0, sum_flag}, 16'h0);
        mb_mask = 16'h0400; #1;
        check("R8 one unmasked", {15'd0, sum_flag}, 16'h1);

        // R8: summary falls on its own after clearing the last unmasked flag
        @(negedge clk);
        step(1'b0, 4'd0, 1'b0, 16'hFFFF, 1'b1, 16'h0001);
        check_outs("R8 drop after clear");
        check("R8 sum low", {15'd0, sum_flag}, 16'h0);

        // R2: reset in mid-operation clears everything
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model = '0;
        check_outs("R2 mid reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule